// File: doc/BRIEF.md
# Translation Lookaside Buffer with Privilege and Permission Checking

The block keeps a small, fully associative set of page translations. On every lookup it turns a virtual address into a physical address in the same cycle and checks the access against the entry's rights and the current privilege mode. It has no internal pipeline, so a core can run it next to its first-level cache access. Each entry maps either a small page or a large page. Each entry also carries read, write and execute grants, a kernel-only flag, a dirty bit and a use bit.

A lookup that finds no entry raises a miss. An external miss handler, in hardware or software, then walks the page tables and installs the entry through the fill port. A fill goes to the lowest-numbered empty slot. When no slot is empty, the fill replaces the lowest-numbered entry whose use bit is clear, which gives an approximate least-recently-used policy. A flush input empties the whole buffer in one cycle.

Both the lookup port and the fill port use a valid/ready pair. A transfer happens in a cycle where valid and ready are both high. The block drops ready on both ports only while `flush` is high. The lookup result is combinational and is valid only in the cycle of the transfer. A requester that sees ready low holds its request and presents it again. The block does not queue requests.

Top module: `tlb_prot`

## Requirements
- R1: Reset or one cycle of `flush` marks every entry invalid and clears every use bit. Until the next fill, every accepted lookup reports `rs_miss`=1 and `rs_hit`=0.
- R2: For a small (4 KiB) page, an accepted lookup whose `lk_vaddr[31:12]` equals the stored page number sets `rs_hit` in the same cycle, with `rs_paddr` = {stored frame number, `lk_vaddr[11:0]`}. A lookup that matches no valid entry sets `rs_miss` and drives `rs_paddr` to 0.
- R3: For a large (4 MiB) page, only `lk_vaddr[31:22]` is compared, against the upper 10 bits of the stored page number. On a hit, `rs_paddr` = {upper 10 bits of the stored frame number, `lk_vaddr[21:0]`}.
- R4: A hit on a kernel-only entry with `lk_user`=1 sets `rs_fault`, whatever the access type. The same access with `lk_user`=0 is judged only by the grant bits.
- R5: `lk_acc` encodes 00 read, 01 write and 10 execute. Code 11 always faults. A hit whose access type lacks its grant sets `rs_fault`, so a page granted read but not write faults on a write and passes on a read. `rs_fault` is only ever set together with `rs_hit`.
- R6: `rs_dirty` shows the hit entry's stored dirty bit. A write hit that does not fault sets that bit for later lookups. A faulting write leaves it clear. A fill clears it.
- R7: Every hit, faulting or not, and every fill sets the use bit of the entry concerned. If that would make every use bit set, only the bits just set stay set.
- R8: A fill goes to the lowest-numbered invalid entry. When every entry is valid, it goes to the lowest-numbered entry whose use bit is clear.
- R9: When two or more valid entries match, the lookup sets `rs_multi` and `rs_miss`, keeps `rs_hit` and `rs_fault` low, and changes no use or dirty bit.
- R10: `lk_ready` and `fill_ready` equal `!flush`. All result outputs stay low unless a lookup is accepted. A lookup accepted in the same cycle as a fill sees the contents from before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries at the next edge |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access type: 00 read, 01 write, 10 execute, 11 reserved |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| rs_hit | output | 1 | Exactly one entry matched |
| rs_miss | output | 1 | No usable translation (none or several matched) |
| rs_multi | output | 1 | Several entries matched |
| rs_fault | output | 1 | Hit, but access denied |
| rs_dirty | output | 1 | Dirty bit of the hit entry before this access |
| rs_paddr | output | 32 | Translated physical address |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | Fill can be accepted |
| fill_vpn | input | 20 | Virtual page number of the new entry |
| fill_ppn | input | 20 | Physical frame number of the new entry |
| fill_large | input | 1 | 1 = large page |
| fill_rd | input | 1 | Read grant |
| fill_wr | input | 1 | Write grant |
| fill_ex | input | 1 | Execute grant |
| fill_kern | input | 1 | Kernel-only entry |

## Verification
The bench goes after the cases a slightly wrong design would get wrong. It fills the buffer completely and then checks which entry a new fill displaces and that the use bits reset when they saturate. A design without the saturation clear would fall back to slot 0 and lose a recently used page. A design that ignores use bits would evict the wrong page. Large-page lookups use low address bits that differ from the stored ones, which catches a design that compares the full page number. Other cases check that a kernel-only page faults from user mode on every access type and that a faulting write leaves the dirty bit clear. They also check that a duplicated page number reports a multi-hit and not a translation, and that a lookup in the same cycle as a fill does not see the new entry.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_RSV = 2'b11
  } acc_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
    logic kern;
  } perm_t;
endpackage

// File: rtl/tlb_match_bank.sv
// One comparator per entry; large entries ignore the low page-number bits.
module tlb_match_bank #(
  parameter int N_ENTRIES = 16,
  parameter int VPN_W     = 20,
  parameter int LG_BITS   = 10
) (
  input  logic [N_ENTRIES-1:0]            ent_valid,
  input  logic [N_ENTRIES-1:0]            ent_large,
  input  logic [N_ENTRIES-1:0][VPN_W-1:0] ent_vpn,
  input  logic [VPN_W-1:0]                q_vpn,
  output logic [N_ENTRIES-1:0]            match
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    logic eq_small, eq_large;
    assign eq_small = (ent_vpn[g] == q_vpn);
    assign eq_large = (ent_vpn[g][VPN_W-1:LG_BITS] == q_vpn[VPN_W-1:LG_BITS]);
    assign match[g] = ent_valid[g] && (ent_large[g] ? eq_large : eq_small);
  end
endmodule

// File: rtl/tlb_hit_enc.sv
// Encodes the match vector and flags more than one match.
module tlb_hit_enc #(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = 4
) (
  input  logic [N_ENTRIES-1:0] match,
  output logic                 any,
  output logic                 multi,
  output logic [IDX_W-1:0]     idx
);
  localparam int CNT_W = $clog2(N_ENTRIES + 1);
  logic [CNT_W-1:0] cnt;

  always_comb begin
    idx = '0;
    cnt = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (match[i]) begin
        idx = IDX_W'(i);
        cnt = cnt + 1'b1;
      end
    end
  end

  assign any   = (cnt != '0);
  assign multi = (cnt > CNT_W'(1));
endmodule

// File: rtl/tlb_perm_chk.sv
// Privilege and grant evaluation for the selected entry.
module tlb_perm_chk
  import tlb_pkg::*;
(
  input  perm_t      perm,
  input  logic [1:0] acc,
  input  logic       user,
  output logic       fault
);
  logic denied;

  always_comb begin
    unique case (acc_e'(acc))
      ACC_RD:  denied = !perm.rd;
      ACC_WR:  denied = !perm.wr;
      ACC_EX:  denied = !perm.ex;
      default: denied = 1'b1;
    endcase
    fault = denied || (user && perm.kern);
  end
endmodule

// File: rtl/tlb_repl.sv
// Victim picker: lowest invalid slot, else lowest slot with a clear use bit.
module tlb_repl #(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = 4
) (
  input  logic [N_ENTRIES-1:0] valid,
  input  logic [N_ENTRIES-1:0] used,
  output logic [IDX_W-1:0]     victim
);
  logic             have_inv, have_old;
  logic [IDX_W-1:0] inv_idx, old_idx;

  always_comb begin
    have_inv = 1'b0;
    have_old = 1'b0;
    inv_idx  = '0;
    old_idx  = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        have_inv = 1'b1;
        inv_idx  = IDX_W'(i);
      end
      if (!used[i]) begin
        have_old = 1'b1;
        old_idx  = IDX_W'(i);
      end
    end
    if (have_inv)      victim = inv_idx;
    else if (have_old) victim = old_idx;
    else               victim = '0;
  end
endmodule

// File: rtl/tlb_prot.sv
module tlb_prot
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int SMALL_OFF = 12,
  parameter int LARGE_OFF = 22
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      lk_valid,
  output logic                      lk_ready,
  input  logic [VA_W-1:0]           lk_vaddr,
  input  logic [1:0]                lk_acc,
  input  logic                      lk_user,
  output logic                      rs_hit,
  output logic                      rs_miss,
  output logic                      rs_multi,
  output logic                      rs_fault,
  output logic                      rs_dirty,
  output logic [PA_W-1:0]           rs_paddr,
  input  logic                      fill_valid,
  output logic                      fill_ready,
  input  logic [VA_W-SMALL_OFF-1:0] fill_vpn,
  input  logic [PA_W-SMALL_OFF-1:0] fill_ppn,
  input  logic                      fill_large,
  input  logic                      fill_rd,
  input  logic                      fill_wr,
  input  logic                      fill_ex,
  input  logic                      fill_kern
);
  localparam int VPN_W   = VA_W - SMALL_OFF;
  localparam int PPN_W   = PA_W - SMALL_OFF;
  localparam int LG_BITS = LARGE_OFF - SMALL_OFF;
  localparam int IDX_W   = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  // Entry storage
  logic  [N_ENTRIES-1:0]            e_valid, e_use, e_dirty, e_large;
  logic  [N_ENTRIES-1:0][VPN_W-1:0] e_vpn;
  logic  [N_ENTRIES-1:0][PPN_W-1:0] e_ppn;
  perm_t [N_ENTRIES-1:0]            e_perm;

  // Lookup path
  logic                 lk_fire, fill_fire;
  logic [N_ENTRIES-1:0] match;
  logic                 any_match, multi_match, single;
  logic [IDX_W-1:0]     hit_idx, victim;
  logic                 hit_large, perm_fault;
  perm_t                hit_perm;
  logic [PPN_W-1:0]     hit_ppn;

  assign lk_ready   = !flush;
  assign fill_ready = !flush;
  assign lk_fire    = lk_valid && lk_ready;
  assign fill_fire  = fill_valid && fill_ready;

  tlb_match_bank #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .LG_BITS(LG_BITS)) u_match (
    .ent_valid (e_valid),
    .ent_large (e_large),
    .ent_vpn   (e_vpn),
    .q_vpn     (lk_vaddr[VA_W-1:SMALL_OFF]),
    .match     (match)
  );

  tlb_hit_enc #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_enc (
    .match (match),
    .any   (any_match),
    .multi (multi_match),
    .idx   (hit_idx)
  );

  assign hit_large = e_large[hit_idx];
  assign hit_perm  = e_perm[hit_idx];
  assign hit_ppn   = e_ppn[hit_idx];

  tlb_perm_chk u_perm (
    .perm  (hit_perm),
    .acc   (lk_acc),
    .user  (lk_user),
    .fault (perm_fault)
  );

  tlb_repl #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_repl (
    .valid  (e_valid),
    .used   (e_use),
    .victim (victim)
  );

  assign single   = any_match && !multi_match;
  assign rs_hit   = lk_fire && single;
  assign rs_miss  = lk_fire && !single;
  assign rs_multi = lk_fire && multi_match;
  assign rs_fault = rs_hit && perm_fault;
  assign rs_dirty = rs_hit && e_dirty[hit_idx];

  always_comb begin
    rs_paddr = '0;
    if (rs_hit) begin
      if (hit_large)
        rs_paddr = {hit_ppn[PPN_W-1:LG_BITS], lk_vaddr[LARGE_OFF-1:0]};
      else
        rs_paddr = {hit_ppn, lk_vaddr[SMALL_OFF-1:0]};
    end
  end

  // Use-bit next state with saturation clear
  logic [N_ENTRIES-1:0] set_mask, use_or, use_nx;
  logic                 dirty_set;

  always_comb begin
    set_mask = '0;
    if (rs_hit)    set_mask[hit_idx] = 1'b1;
    if (fill_fire) set_mask[victim]  = 1'b1;
    use_or = e_use | set_mask;
    use_nx = (&use_or) ? set_mask : use_or;
  end

  assign dirty_set = rs_hit && !perm_fault && (acc_e'(lk_acc) == ACC_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid <= '0;
      e_use   <= '0;
      e_dirty <= '0;
      e_large <= '0;
      e_vpn   <= '0;
      e_ppn   <= '0;
      e_perm  <= '0;
    end else if (flush) begin
      e_valid <= '0;
      e_use   <= '0;
    end else begin
      e_use <= use_nx;
      if (dirty_set) e_dirty[hit_idx] <= 1'b1;
      if (fill_fire) begin
        e_valid[victim] <= 1'b1;
        e_dirty[victim] <= 1'b0;
        e_large[victim] <= fill_large;
        e_vpn[victim]   <= fill_vpn;
        e_ppn[victim]   <= fill_ppn;
        e_perm[victim]  <= '{rd: fill_rd, wr: fill_wr, ex: fill_ex, kern: fill_kern};
      end
    end
  end
endmodule

// File: rtl/tlb_prot_chk.sv
module tlb_prot_chk #(
  parameter int N_ENTRIES = 16,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int LARGE_OFF = 22,
  parameter int IDX_W     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 flush,
  input logic                 lk_ready,
  input logic                 fill_ready,
  input logic [VA_W-1:0]      lk_vaddr,
  input logic [1:0]           lk_acc,
  input logic                 lk_user,
  input logic                 rs_hit,
  input logic                 rs_miss,
  input logic                 rs_multi,
  input logic                 rs_fault,
  input logic [PA_W-1:0]      rs_paddr,
  input logic                 fill_fire,
  input logic [IDX_W-1:0]     hit_idx,
  input logic                 hit_large,
  input logic [3:0]           hit_perm,
  input logic [N_ENTRIES-1:0] e_dirty,
  input logic [N_ENTRIES-1:0] e_use
);
  p_flush_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rs_hit);

  p_hit_miss_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rs_hit && rs_miss));

  p_large_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_hit && hit_large) |-> (rs_paddr[LARGE_OFF-1:0] == lk_vaddr[LARGE_OFF-1:0]));

  // hit_perm[0] is the kernel-only flag
  p_user_kern_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_hit && lk_user && hit_perm[0]) |-> rs_fault);

  p_fault_on_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rs_fault |-> rs_hit);

  p_dirty_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_hit && !rs_fault && lk_acc == 2'b01 && !fill_fire) |=> e_dirty[$past(hit_idx)]);

  p_use_never_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (N_ENTRIES > 1) |-> !(&e_use));

  p_multi_is_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rs_multi |-> (rs_miss && !rs_hit && !rs_fault));

  p_flush_backpressure_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!lk_ready && !fill_ready));
endmodule

bind tlb_prot tlb_prot_chk #(
  .N_ENTRIES (N_ENTRIES),
  .VA_W      (VA_W),
  .PA_W      (PA_W),
  .LARGE_OFF (LARGE_OFF),
  .IDX_W     (IDX_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .lk_ready   (lk_ready),
  .fill_ready (fill_ready),
  .lk_vaddr   (lk_vaddr),
  .lk_acc     (lk_acc),
  .lk_user    (lk_user),
  .rs_hit     (rs_hit),
  .rs_miss    (rs_miss),
  .rs_multi   (rs_multi),
  .rs_fault   (rs_fault),
  .rs_paddr   (rs_paddr),
  .fill_fire  (fill_fire),
  .hit_idx    (hit_idx),
  .hit_large  (hit_large),
  .hit_perm   (hit_perm),
  .e_dirty    (e_dirty),
  .e_use      (e_use)
);

// File: tb/tlb_prot_tb.sv
`timescale 1ns/1ps
module tlb_prot_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_acc = '0;
  logic        lk_user = 1'b0;
  logic        rs_hit, rs_miss, rs_multi, rs_fault, rs_dirty;
  logic [31:0] rs_paddr;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic        fill_large = 1'b0, fill_rd = 1'b0, fill_wr = 1'b0, fill_ex = 1'b0, fill_kern = 1'b0;

  int checks = 0;
  int errors = 0;

  // captured lookup result
  logic        c_hit, c_miss, c_multi, c_fault, c_dirty;
  logic [31:0] c_paddr;

  always #5 clk = ~clk;

  tlb_prot dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr),
    .lk_acc(lk_acc), .lk_user(lk_user),
    .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_multi(rs_multi),
    .rs_fault(rs_fault), .rs_dirty(rs_dirty), .rs_paddr(rs_paddr),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_large(fill_large), .fill_rd(fill_rd),
    .fill_wr(fill_wr), .fill_ex(fill_ex), .fill_kern(fill_kern)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic lg,
                          input logic r, input logic w, input logic x, input logic k);
    fill_vpn = vpn; fill_ppn = ppn; fill_large = lg;
    fill_rd = r; fill_wr = w; fill_ex = x; fill_kern = k;
  endtask

  task automatic do_fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic lg,
                         input logic r, input logic w, input logic x, input logic k);
    @(negedge clk);
    set_fill(vpn, ppn, lg, r, w, x, k);
    fill_valid = 1'b1;
    @(posedge clk);
    #1 fill_valid = 1'b0;
  endtask

  task automatic capture();
    c_hit = rs_hit; c_miss = rs_miss; c_multi = rs_multi;
    c_fault = rs_fault; c_dirty = rs_dirty; c_paddr = rs_paddr;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] acc, input logic usr);
    @(negedge clk);
    lk_vaddr = va; lk_acc = acc; lk_user = usr; lk_valid = 1'b1;
    #1 capture();
    @(posedge clk);
    #1 lk_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    #1 flush = 1'b0;
  endtask

  task automatic t_reset();
    lookup(32'h1234_5678, 2'b00, 1'b0);
    chk("R1", "miss after reset", 32'(c_miss), 32'd1);
    chk("R1", "hit after reset", 32'(c_hit), 32'd0);
    chk("R10", "lk_ready idle", 32'(lk_ready), 32'd1);
    chk("R10", "fill_ready idle", 32'(fill_ready), 32'd1);
  endtask

  task automatic t_small();
    do_flush();
    do_fill(20'h12345, 20'hABCDE, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    lookup(32'h1234_5678, 2'b00, 1'b1);
    chk("R2", "small hit", 32'(c_hit), 32'd1);
    chk("R2", "small paddr", c_paddr, 32'hABCD_E678);
    chk("R2", "small no fault", 32'(c_fault), 32'd0);
    lookup(32'h1234_6678, 2'b00, 1'b1);
    chk("R2", "neighbour page miss", 32'(c_miss), 32'd1);
    chk("R2", "paddr zero on miss", c_paddr, 32'd0);
    @(negedge clk);
    lk_vaddr = 32'h1234_5678; lk_valid = 1'b0;
    #1 chk("R10", "no result without valid", {28'd0, rs_hit, rs_miss, rs_fault, rs_multi}, 32'd0);
  endtask

  task automatic t_large();
    do_fill(20'hC0155, 20'h5A3FF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    lookup(32'hC01F_ABCD, 2'b00, 1'b1);
    chk("R3", "large hit, low vpn bits differ", 32'(c_hit), 32'd1);
    chk("R3", "large paddr", c_paddr, 32'h5A1F_ABCD);
    lookup(32'hC040_0000, 2'b00, 1'b1);
    chk("R3", "next large region miss", 32'(c_miss), 32'd1);
  endtask

  task automatic t_kern();
    do_fill(20'h00010, 20'h00777, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int a = 0; a < 3; a++) begin
      lookup(32'h0001_0004, 2'(a), 1'b1);
      chk("R4", $sformatf("user on kernel page acc=%0d fault", a), 32'(c_fault), 32'd1);
      chk("R4", "user on kernel page still hit", 32'(c_hit), 32'd1);
    end
    lookup(32'h0001_0004, 2'b01, 1'b0);
    chk("R4", "kernel write allowed", 32'(c_fault), 32'd0);
    chk("R4", "kernel paddr", c_paddr, 32'h0077_7004);
  endtask

  task automatic t_perm();
    do_fill(20'h00020, 20'h00888, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    lookup(32'h0002_0010, 2'b00, 1'b1);
    chk("R5", "read on read-only ok", 32'(c_fault), 32'd0);
    lookup(32'h0002_0010, 2'b01, 1'b1);
    chk("R5", "write on read-only faults", 32'(c_fault), 32'd1);
    lookup(32'h0002_0010, 2'b10, 1'b0);
    chk("R5", "exec without grant faults", 32'(c_fault), 32'd1);
    lookup(32'h0002_0010, 2'b11, 1'b0);
    chk("R5", "reserved code faults", 32'(c_fault), 32'd1);
  endtask

  task automatic t_dirty();
    do_fill(20'h00030, 20'h00999, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    lookup(32'h0003_0000, 2'b01, 1'b1);
    chk("R6", "dirty clear on first write", 32'(c_dirty), 32'd0);
    lookup(32'h0003_0000, 2'b00, 1'b1);
    chk("R6", "dirty set after write", 32'(c_dirty), 32'd1);
    lookup(32'h0002_0010, 2'b01, 1'b1);
    lookup(32'h0002_0010, 2'b00, 1'b1);
    chk("R6", "faulting write leaves dirty clear", 32'(c_dirty), 32'd0);
  endtask

  task automatic t_victim();
    do_flush();
    for (int i = 0; i < 16; i++)
      do_fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++)
      lookup({20'h00100 + 20'(i), 12'h000}, 2'b00, 1'b0);
    // use bits now: slots 0..4 and 15, so victim is slot 5
    do_fill(20'h001FF, 20'h002FF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    lookup(32'h0010_5000, 2'b00, 1'b0);
    chk("R8", "slot 5 page evicted", 32'(c_miss), 32'd1);
    lookup(32'h001F_F123, 2'b00, 1'b0);
    chk("R8", "new page hit", c_paddr, 32'h002F_F123);
    lookup(32'h0010_0000, 2'b00, 1'b0);
    chk("R7", "saturation clear kept slot 0", 32'(c_hit), 32'd1);
    lookup(32'h0010_F000, 2'b00, 1'b0);
    chk("R8", "last filled page kept", 32'(c_hit), 32'd1);
    do_fill(20'h001FE, 20'h002FE, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    lookup(32'h0010_6000, 2'b00, 1'b0);
    chk("R7", "next unused slot 6 evicted", 32'(c_miss), 32'd1);
    lookup(32'h0010_7000, 2'b00, 1'b0);
    chk("R7", "slot 7 kept", 32'(c_hit), 32'd1);
  endtask

  task automatic t_multi();
    do_flush();
    do_fill(20'h00050, 20'h00001, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    do_fill(20'h00050, 20'h00002, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    lookup(32'h0005_0000, 2'b11, 1'b1);
    chk("R9", "multi flag", 32'(c_multi), 32'd1);
    chk("R9", "multi reports miss", 32'(c_miss), 32'd1);
    chk("R9", "no hit or fault", {30'd0, c_hit, c_fault}, 32'd0);
  endtask

  task automatic t_flush();
    do_fill(20'h00070, 20'h00070, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    flush = 1'b1;
    #1 chk("R10", "ready low during flush", {30'd0, lk_ready, fill_ready}, 32'd0);
    @(posedge clk);
    #1 flush = 1'b0;
    lookup(32'h0007_0000, 2'b00, 1'b0);
    chk("R1", "miss after flush", 32'(c_miss), 32'd1);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    set_fill(20'h00080, 20'h00123, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    fill_valid = 1'b1;
    lk_vaddr = 32'h0008_0ABC; lk_acc = 2'b00; lk_user = 1'b0; lk_valid = 1'b1;
    #1 capture();
    @(posedge clk);
    #1 begin fill_valid = 1'b0; lk_valid = 1'b0; end
    chk("R10", "lookup beside fill sees old contents", 32'(c_miss), 32'd1);
    lookup(32'h0008_0ABC, 2'b00, 1'b0);
    chk("R10", "hit on following cycle", c_paddr, 32'h0012_3ABC);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_small();
    t_large();
    t_kern();
    t_perm();
    t_dirty();
    t_victim();
    t_multi();
    t_flush();
    t_same_cycle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule